// File: doc/BRIEF.md
# Comparator-Feedback Charge-Balancing ADC Sequencer

This block turns a one-bit comparator input and one feedback output that can be tri-stated into a charge-balancing analog-to-digital converter. An RC network on the feedback pin holds a voltage. An external comparator checks that voltage against the unknown input. The block divides time into fixed pulse periods of 24 clocks. At the first cycle of each period it reads the synchronized comparator and picks one of two fixed waveforms for that period. The "charge" waveform pushes the capacitor voltage up. The "discharge" waveform lets it fall.

A conversion has two passes. Each pass lasts a programmed number of periods. The first pass only settles the capacitor and its count is discarded. Both counters are then reloaded, and the measured pass follows with no gap. The result is the programmed total minus the number of discharge periods in the measured pass. An outside agent turns the result into a voltage by interpolating linearly between the two levels the waveforms settle to, at 5/24 and 16/24 of the supply.

States: `ST_IDLE` (output released, waiting for start), `ST_PRIME` (one cycle, output enabled and driven high), `ST_SETTLE` (warm-up pass) and `ST_MEASURE` (counted pass). The transitions are:
- IDLE→PRIME on an accepted start.
- PRIME→SETTLE always.
- SETTLE→MEASURE when the settle pass ends.
- MEASURE→IDLE when the measured pass ends.

Top module: `pwm_adc_seq`

## Requirements
- R1: A pulse period is exactly 24 clocks long. In its first cycle the block chooses the waveform from `cmp_i` as sampled on the clock edge that starts the previous cycle, which is two flops deep. Phase 0 of period k (k counts from 0 across both passes) is the cycle after edge 1+24k, where edge 0 is the start edge.
- R2: When the sampled comparator is 1, the period drives `fb_o` low for phases 0..7 and high for phases 8..23.
- R3: When the sampled comparator is 0, the period drives `fb_o` high for phases 0..4 and low for phases 5..23.
- R4: The count register is loaded with the total at the start of each pass. It decrements once for every period that used the R3 waveform. The result equals the total minus the number of R3 periods in the measured pass (periods T..2T-1).
- R5: Each pass lasts exactly T periods. The settle pass is followed at once by the measured pass. `done_o` rises in the cycle after edge 1+48T, and `busy_o` falls in that same cycle.
- R6: The cycle after the start edge drives `fb_oe_o`=1 and `fb_o`=1. Outside a conversion, `fb_oe_o`=0 and `fb_o`=0.
- R7: `total_i` is latched when start is accepted. A value of 0 is treated as 1.
- R8: `start_i` is ignored while `busy_o` is high. Neither the timing nor the result of the running conversion changes.
- R9: `done_o` is high for exactly one cycle. `count_o` changes only in that cycle and holds its value through the whole next conversion.
- R10: A synchronous active-high `rst` returns the block to idle with `fb_oe_o`, `fb_o`, `busy_o`, `done_o` and `count_o` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, accepted only when idle |
| total_i | input | 8 | Periods per pass, latched at start |
| cmp_i | input | 1 | Asynchronous comparator, 1 = capacitor below input |
| fb_o | output | 1 | Feedback drive level |
| fb_oe_o | output | 1 | Feedback output enable |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when the result updates |
| count_o | output | 8 | Result of the last finished conversion |

## Verification
The assertions assume three things about the inputs. `cmp_i` may change in any cycle but is only meaningful at period starts. `rst` is held for at least one edge before any check counts. A start pulse can arrive at any time. The stimulus changes `cmp_i` half a period before each sampling edge, so the value in force for period k is known exactly. It also sends extra start pulses with a different total in the middle of conversions. The sweeps cover small totals, including 0 and 1, under several comparator patterns, plus two long totals and a reset asserted mid-conversion.

// File: rtl/pwm_adc_pkg.sv
package pwm_adc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PRIME   = 2'd1,
        ST_SETTLE  = 2'd2,
        ST_MEASURE = 2'd3
    } seq_state_t;
endpackage

// File: rtl/pwm_adc_sync.sv
module pwm_adc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwm_adc_period.sv
module pwm_adc_period #(
    parameter int PERIOD  = 24,
    parameter int UP_LOW  = 8,
    parameter int DN_HIGH = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic cmp_s,
    output logic wave,
    output logic period_end,
    output logic period_down
);
    localparam int PH_W = $clog2(PERIOD);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0] UP_EDGE = PH_W'(UP_LOW);
    localparam logic [PH_W-1:0] DN_EDGE = PH_W'(DN_HIGH);

    logic [PH_W-1:0] phase_q;
    logic            up_q;
    logic            up_cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            up_q    <= 1'b0;
        end else if (!run) begin
            phase_q <= '0;
        end else begin
            phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
            if (phase_q == '0) up_q <= cmp_s;
        end
    end

    always_comb begin
        up_cur      = (phase_q == '0) ? cmp_s : up_q;
        wave        = up_cur ? (phase_q >= UP_EDGE) : (phase_q < DN_EDGE);
        period_end  = run && (phase_q == PH_LAST);
        period_down = !up_cur;
    end

    p_phase_bound_r1: assert property (@(posedge clk) disable iff (rst)
        phase_q <= PH_LAST);

    p_phase_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && phase_q == '0) |-> ($past(phase_q) == PH_LAST));

    p_choice_held_r2: assert property (@(posedge clk) disable iff (rst)
        (run && phase_q >= PH_W'(2)) |-> $stable(up_q));
endmodule

// File: rtl/pwm_adc_counters.sv
module pwm_adc_counters #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             down,
    output logic [CNT_W-1:0] ton_o,
    output logic [CNT_W-1:0] tot_o,
    output logic             pass_last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] ton_q;
    logic [CNT_W-1:0] tot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ton_q <= '0;
            tot_q <= '0;
        end else if (load) begin
            ton_q <= load_val;
            tot_q <= load_val;
        end else if (tick) begin
            tot_q <= tot_q - ONE;
            if (down) ton_q <= ton_q - ONE;
        end
    end

    assign ton_o     = ton_q;
    assign tot_o     = tot_q;
    assign pass_last = tick && (tot_q == ONE);

    p_ton_ge_tot_r4: assert property (@(posedge clk) disable iff (rst)
        ton_q >= tot_q);

    p_ton_step_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> (ton_q == ($past(down) ? $past(ton_q) - ONE : $past(ton_q))));

    p_tot_step_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> (tot_q == $past(tot_q) - ONE));
endmodule

// File: rtl/pwm_adc_seq.sv
module pwm_adc_seq
    import pwm_adc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PERIOD      = 24,
    parameter int UP_LOW      = 8,
    parameter int DN_HIGH     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] total_i,
    input  logic             cmp_i,
    output logic             fb_o,
    output logic             fb_oe_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] total_q;
    logic [CNT_W-1:0] count_q;
    logic             done_q;
    logic             cmp_s;
    logic             run;
    logic             wave;
    logic             period_end;
    logic             period_down;
    logic [CNT_W-1:0] ton;
    logic [CNT_W-1:0] tot;
    logic             pass_last;
    logic             start_ok;
    logic [CNT_W-1:0] total_eff;
    logic             load;
    logic [CNT_W-1:0] load_val;

    pwm_adc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (cmp_i),
        .q_o (cmp_s)
    );

    pwm_adc_period #(.PERIOD(PERIOD), .UP_LOW(UP_LOW), .DN_HIGH(DN_HIGH)) u_period (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .cmp_s       (cmp_s),
        .wave        (wave),
        .period_end  (period_end),
        .period_down (period_down)
    );

    pwm_adc_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_val  (load_val),
        .tick      (period_end),
        .down      (period_down),
        .ton_o     (ton),
        .tot_o     (tot),
        .pass_last (pass_last)
    );

    assign start_ok  = (state_q == ST_IDLE) && start_i;
    assign total_eff = (total_i == '0) ? ONE : total_i;
    assign load      = start_ok || ((state_q == ST_SETTLE) && pass_last);
    assign load_val  = start_ok ? total_eff : total_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_ok) state_d = ST_PRIME;
            ST_PRIME:   state_d = ST_SETTLE;
            ST_SETTLE:  if (pass_last) state_d = ST_MEASURE;
            ST_MEASURE: if (pass_last) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        run     = 1'b0;
        fb_o    = 1'b0;
        fb_oe_o = 1'b0;
        busy_o  = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
            end
            ST_PRIME: begin
                fb_oe_o = 1'b1;
                fb_o    = 1'b1;
            end
            ST_SETTLE, ST_MEASURE: begin
                run     = 1'b1;
                fb_oe_o = 1'b1;
                fb_o    = wave;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            total_q <= '0;
            count_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_ok) total_q <= total_eff;
            if ((state_q == ST_MEASURE) && pass_last) begin
                count_q <= period_down ? ton - ONE : ton;
                done_q  <= 1'b1;
            end
        end
    end

    assign done_o  = done_q;
    assign count_o = count_q;

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    p_result_only_on_done_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(count_q) |-> done_q);

    p_idle_released_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (!fb_oe_o && !fb_o));

    p_prime_high_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PRIME) |-> (fb_oe_o && fb_o));

    p_total_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(total_q));

    p_total_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        start_ok |=> (total_q != '0));

    p_measure_follows_settle_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETTLE && pass_last) |=> (state_q == ST_MEASURE));
endmodule

// File: tb/tb_pwm_adc_seq.sv
module tb_pwm_adc_seq;
    logic       clk = 1'b0;
    logic       rst;
    logic       start_i;
    logic [7:0] total_i;
    logic       cmp_i;
    logic       fb_o, fb_oe_o, busy_o, done_o;
    logic [7:0] count_o;

    int checks = 0;
    int errors = 0;
    int prev_result = 0;

    always #10 clk = ~clk;

    pwm_adc_seq dut (
        .clk(clk), .rst(rst), .start_i(start_i), .total_i(total_i), .cmp_i(cmp_i),
        .fb_o(fb_o), .fb_oe_o(fb_oe_o), .busy_o(busy_o), .done_o(done_o), .count_o(count_o)
    );

    function automatic logic pat(int kind, int k);
        case (kind)
            0: return 1'b1;
            1: return 1'b0;
            2: return k[0];
            3: return (k % 3) != 0;
            4: return ((k * 7 + 3) % 5) < 2;
            default: return (((k * 13) ^ (k >> 2)) & 1) == 1;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One conversion; poke sends a second start with another total mid-run (R8)
    task automatic convert(int total, int kind, bit poke);
        int t;
        int last;
        int downs;
        int exp_res;
        int wave_bad;
        int bad_cyc;
        bit exp_fb;
        t = (total == 0) ? 1 : total;
        last = 48 * t;
        downs = 0;
        for (int k = t; k < 2 * t; k++) if (!pat(kind, k)) downs++;
        exp_res = t - downs;
        wave_bad = 0;
        bad_cyc = -1;
        @(negedge clk);
        start_i = 1'b1;
        total_i = 8'(total);
        cmp_i = pat(kind, 0);
        @(posedge clk);
        for (int n = 0; n <= last + 2; n++) begin
            @(negedge clk);
            if (n == 0) begin
                // R6: primed high, enabled
                if (!(fb_oe_o && fb_o && busy_o && !done_o)) begin
                    wave_bad++;
                    if (bad_cyc < 0) bad_cyc = n;
                end
            end else if (n <= last) begin
                // R1/R2/R3: per-period waveform from comparator
                int k;
                int ph;
                k = (n - 1) / 24;
                ph = (n - 1) % 24;
                exp_fb = pat(kind, k) ? (ph >= 8) : (ph < 5);
                if (fb_o != exp_fb || !fb_oe_o || !busy_o || done_o) begin
                    wave_bad++;
                    if (bad_cyc < 0) bad_cyc = n;
                end
                if (n == last) check("R9 result held during conversion", int'(count_o), prev_result);
            end else if (n == last + 1) begin
                check("R5 done at 1+48T", int'(done_o), 1);
                check("R5 busy low at done", int'(busy_o), 0);
                check("R4 result", int'(count_o), exp_res);
                check("R6 released after conversion", int'({fb_oe_o, fb_o}), 0);
            end else begin
                check("R9 done one cycle", int'(done_o), 0);
                check("R9 result stable after done", int'(count_o), exp_res);
            end
            start_i = 1'b0;
            if (poke && n == 30 && last > 31) begin
                start_i = 1'b1;
                total_i = 8'(total + 3);
            end
            cmp_i = pat(kind, (n + 12) / 24);
        end
        check("R1 R2 R3 waveform mismatches", wave_bad, 0);
        if (wave_bad != 0) $display("  first waveform mismatch at cycle %0d (T=%0d kind=%0d)", bad_cyc, t, kind);
        prev_result = exp_res;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int totals[7];
        totals = '{0, 1, 2, 3, 5, 8, 13};
        rst = 1'b1;
        start_i = 1'b0;
        total_i = 8'd0;
        cmp_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        check("R10 reset busy", int'(busy_o), 0);
        check("R10 reset done", int'(done_o), 0);
        check("R10 reset oe/fb", int'({fb_oe_o, fb_o}), 0);
        check("R10 reset count", int'(count_o), 0);

        // R7: zero total behaves as 1; sweep small totals and patterns
        foreach (totals[i]) begin
            for (int kind = 0; kind < 6; kind++) begin
                convert(totals[i], kind, (kind % 2) == 1);
            end
        end
        convert(100, 4, 1'b1);
        convert(255, 5, 1'b1);

        // R10: reset in the middle of a conversion
        @(negedge clk);
        start_i = 1'b1;
        total_i = 8'd5;
        @(negedge clk);
        start_i = 1'b0;
        repeat (40) @(negedge clk);
        check("R10 busy before mid reset", int'(busy_o), 1);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R10 mid reset busy", int'(busy_o), 0);
        check("R10 mid reset oe/fb", int'({fb_oe_o, fb_o}), 0);
        check("R10 mid reset count", int'(count_o), 0);
        check("R10 mid reset done", int'(done_o), 0);
        prev_result = 0;
        convert(4, 2, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule